// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six arithmetic condition flags (carry, parity, half-carry, zero, sign and overflow) for one add, subtract or logic operation at an operand width of 8, 16 or 32 bits. The result can come from an external ALU, together with that ALU's carry out. It can also come from a small adder and subtractor inside the block, which works from the two operands. The flags are produced combinationally in the same cycle as the operands. A write strobe copies them into a status register.

The same status register holds two control bits, interrupt enable and single-step trap. Each has its own set and clear strobes. The block gates an external interrupt request with the interrupt-enable bit. It raises a trap request at every instruction boundary while the trap bit is 1. One 8-bit read port returns the captured flags and both control bits.

Top module: `status_flag_gen`

## Requirements
- R1: Carry flag: on add it is the carry out of the selected width; on subtract it is the borrow, 1 exactly when the first operand is unsigned-less than the second. When the external result source is selected, the carry flag equals `carry_in`.
- R2: Parity flag is 1 when the low 8 bits of the result hold an even number of ones, and 0 when odd, at every width.
- R3: Half-carry flag is bit 4 of (op_a XOR op_b XOR result), which is the carry or borrow from bit 3 into bit 4.
- R4: Zero flag is 1 exactly when the result, masked to the selected width, is zero.
- R5: Sign flag equals the most significant bit of the result at the selected width (bit 7, 15 or 31).
- R6: Overflow: on add it is set when both operands have the same sign and the result sign differs. On subtract it is set when the operand signs differ and the result sign differs from op_a's.
- R7: Logic class (op_class 2 or 3) forces carry, overflow and half-carry to 0 and always takes the result from `res_in`. The codes are: 0 add, 1 subtract.
- R8: Width select encoding: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand and result bits above the selected width have no effect on any flag.
- R9: With `use_int_adder` = 1 and an add or subtract class, the result and carry come from the internal adder. With it at 0, they come from `res_in` and `carry_in`.
- R10: Interrupt enable (read bit 7) is set by `ien_set` and cleared by `ien_clr` on the next clock edge. Clear wins when both are asserted, and the bit holds otherwise.
- R11: `irq_take` is `irq_req` AND the interrupt-enable bit.
- R12: Trap bit (read bit 6) has set and clear strobes with the same rules as R10. `trap_req` is `instr_done` AND the trap bit.
- R13: On a clock edge with `flag_we` = 1, read bits 0..5 capture C, P, A, Z, S, O in that order. Without the strobe they hold. Reset clears all 8 read bits.

Ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_in | input | 32 | Externally computed result |
| carry_in | input | 1 | External carry out or borrow |
| use_int_adder | input | 1 | Select the internal adder for add and subtract |
| op_class | input | 2 | 0 add, 1 subtract, 2/3 logic |
| width_sel | input | 2 | 0 = 8, 1 = 16, 2/3 = 32 bits |
| flag_we | input | 1 | Capture the arithmetic flags into the register |
| ien_set | input | 1 | Set interrupt enable |
| ien_clr | input | 1 | Clear interrupt enable |
| trap_set | input | 1 | Set trap bit |
| trap_clr | input | 1 | Clear trap bit |
| irq_req | input | 1 | External interrupt request |
| instr_done | input | 1 | Instruction boundary pulse |
| flag_cf | output | 1 | Carry or borrow |
| flag_pf | output | 1 | Even parity of the low byte |
| flag_af | output | 1 | Half-carry |
| flag_zf | output | 1 | Zero |
| flag_sf | output | 1 | Sign |
| flag_of | output | 1 | Signed overflow |
| flags_rd | output | 8 | Read port {I, T, O, S, Z, A, P, C} |
| irq_take | output | 1 | Interrupt accepted |
| trap_req | output | 1 | Trap request |

## Verification
The bench targets the points where flags change at a width boundary:
- 0x7F+1 and 0x80-1, where a design that took the overflow sign from the wrong operand would miss signed overflow.
- 0xFF+1 and 0x8000+0x8000, where a design with the wrong carry index would lose the carry.
- Result values whose low byte has a different parity from the full word, which catch a parity computed over all 32 bits.

Subtractions that borrow only inside the low nibble expose a half-carry taken from the wrong bit. Garbage above the selected width exposes a missing mask. Simultaneous set and clear strobes, and a change of operands while `flag_we` is low, show whether the control and capture bits resolve and hold as required.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OPC_ADD    = 2'd0,
    OPC_SUB    = 2'd1,
    OPC_LOGIC  = 2'd2,
    OPC_LOGIC2 = 2'd3
  } opc_e;

  // read-port bit positions
  localparam int RD_C = 0;
  localparam int RD_P = 1;
  localparam int RD_A = 2;
  localparam int RD_Z = 3;
  localparam int RD_S = 4;
  localparam int RD_O = 5;
  localparam int RD_T = 6;
  localparam int RD_I = 7;

  function automatic int f_bits(input logic [1:0] wid);
    case (wid)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_mask(input logic [1:0] wid);
    case (wid)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic f_top(input logic [WORD_W-1:0] v, input logic [1:0] wid);
    case (wid)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[31];
    endcase
  endfunction

  function automatic logic f_even8(input logic [WORD_W-1:0] v);
    return ~^v[7:0];
  endfunction

  function automatic logic f_ovf(input logic sub, input logic sa, input logic sb, input logic sr);
    if (sub) return (sa != sb) && (sr != sa);
    else     return (sa == sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/sflag_adder.sv
module sflag_adder
  import sflag_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        wid,
  output logic [WORD_W-1:0] sum,
  output logic              cout
);
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] am, bm;
  logic [WORD_W:0]   wide_add;
  logic [WORD_W-1:0] diff;

  always_comb begin
    mask     = f_mask(wid);
    am       = a & mask;
    bm       = b & mask;
    wide_add = {1'b0, am} + {1'b0, bm};
    diff     = am - bm;
    if (sub) begin
      sum  = diff & mask;
      cout = (am < bm);
    end else begin
      sum  = wide_add[WORD_W-1:0] & mask;
      cout = wide_add[f_bits(wid)];
    end
  end
endmodule

// File: rtl/sflag_calc.sv
module sflag_calc
  import sflag_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] res,
  input  logic              cin,
  input  logic [1:0]        opc,
  input  logic [1:0]        wid,
  output logic              cf,
  output logic              pf,
  output logic              af,
  output logic              zf,
  output logic              sf,
  output logic              of
);
  logic              is_logic;
  logic [WORD_W-1:0] rm;
  logic [WORD_W-1:0] mix;

  always_comb begin
    is_logic = opc[1];
    rm       = res & f_mask(wid);
    mix      = a ^ b ^ res;
    pf       = f_even8(rm);
    zf       = (rm == '0);
    sf       = f_top(rm, wid);
    cf       = is_logic ? 1'b0 : cin;
    af       = is_logic ? 1'b0 : mix[4];
    of       = is_logic ? 1'b0 :
               f_ovf(opc == OPC_SUB, f_top(a, wid), f_top(b, wid), f_top(rm, wid));
  end
endmodule

// File: rtl/sflag_ctrl.sv
module sflag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (clr_i) bit_q <= 1'b0;
    else if (set_i) bit_q <= 1'b1;
  end
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import sflag_pkg::*;
#(
  parameter int NFLAGS = 6,
  parameter int RD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] res_in,
  input  logic              carry_in,
  input  logic              use_int_adder,
  input  logic [1:0]        op_class,
  input  logic [1:0]        width_sel,
  input  logic              flag_we,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              trap_set,
  input  logic              trap_clr,
  input  logic              irq_req,
  input  logic              instr_done,
  output logic              flag_cf,
  output logic              flag_pf,
  output logic              flag_af,
  output logic              flag_zf,
  output logic              flag_sf,
  output logic              flag_of,
  output logic [RD_W-1:0]   flags_rd,
  output logic              irq_take,
  output logic              trap_req
);
  // named internal events
  logic [WORD_W-1:0] ev_int_sum;
  logic              ev_int_cout;
  logic              ev_pick_int;
  logic [WORD_W-1:0] ev_result;
  logic              ev_carry;
  logic              ien_q, trap_q;
  logic [NFLAGS-1:0] arith_now, arith_q;

  sflag_adder u_add (
    .a(op_a), .b(op_b), .sub(op_class == OPC_SUB), .wid(width_sel),
    .sum(ev_int_sum), .cout(ev_int_cout)
  );

  assign ev_pick_int = use_int_adder && !op_class[1];
  assign ev_result   = ev_pick_int ? ev_int_sum  : res_in;
  assign ev_carry    = ev_pick_int ? ev_int_cout : carry_in;

  sflag_calc u_calc (
    .a(op_a), .b(op_b), .res(ev_result), .cin(ev_carry),
    .opc(op_class), .wid(width_sel),
    .cf(flag_cf), .pf(flag_pf), .af(flag_af),
    .zf(flag_zf), .sf(flag_sf), .of(flag_of)
  );

  sflag_ctrl u_ien  (.clk(clk), .rst_n(rst_n), .set_i(ien_set),  .clr_i(ien_clr),  .bit_q(ien_q));
  sflag_ctrl u_trap (.clk(clk), .rst_n(rst_n), .set_i(trap_set), .clr_i(trap_clr), .bit_q(trap_q));

  assign arith_now = {flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arith_q <= '0;
    else if (flag_we) arith_q <= arith_now;
  end

  always_comb begin
    flags_rd               = '0;
    flags_rd[NFLAGS-1:0]   = arith_q;
    flags_rd[RD_T]         = trap_q;
    flags_rd[RD_I]         = ien_q;
  end

  assign irq_take = irq_req && ien_q;
  assign trap_req = instr_done && trap_q;
endmodule

// File: rtl/sflag_chk.sv
module sflag_chk
  import sflag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_class,
  input logic       flag_we,
  input logic       ien_set,
  input logic       ien_clr,
  input logic       trap_set,
  input logic       trap_clr,
  input logic       irq_req,
  input logic       instr_done,
  input logic       flag_cf,
  input logic       flag_af,
  input logic       flag_zf,
  input logic       flag_sf,
  input logic       flag_of,
  input logic [7:0] flags_rd,
  input logic       irq_take,
  input logic       trap_req
);
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_class[1] |-> (!flag_cf && !flag_of && !flag_af));

  a_r4_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zf |-> !flag_sf);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !flags_rd[RD_I]);

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !ien_clr) |=> flags_rd[RD_I]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_set && !ien_clr) |=> $stable(flags_rd[RD_I]));

  a_r12_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_set && !trap_clr) |=> $stable(flags_rd[RD_T]));

  a_r12_trap_req: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (instr_done && flags_rd[RD_T]));

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_req && flags_rd[RD_I]));

  a_r13_capture: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_rd[RD_C] == $past(flag_cf) && flags_rd[RD_O] == $past(flag_of)));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_rd[5:0]));
endmodule

bind status_flag_gen sflag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_class(op_class), .flag_we(flag_we),
  .ien_set(ien_set), .ien_clr(ien_clr), .trap_set(trap_set), .trap_clr(trap_clr),
  .irq_req(irq_req), .instr_done(instr_done),
  .flag_cf(flag_cf), .flag_af(flag_af), .flag_zf(flag_zf), .flag_sf(flag_sf),
  .flag_of(flag_of), .flags_rd(flags_rd), .irq_take(irq_take), .trap_req(trap_req)
);

// File: tb/status_flag_gen_tb.sv
module status_flag_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // cls, wid, use_int, a, b, res_in, cin, expected {O,S,Z,A,P,C}
  typedef struct packed {
    logic [1:0]  cls;
    logic [1:0]  wid;
    logic        ui;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        ci;
    logic [5:0]  exp;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd0, 1'b1, 32'h0000_007F, 32'h0000_0001, 32'h0, 1'b0, 6'b110100},
    '{2'd0, 2'd0, 1'b1, 32'h0000_00FF, 32'h0000_0001, 32'h0, 1'b0, 6'b001111},
    '{2'd1, 2'd0, 1'b1, 32'h0000_0000, 32'h0000_0001, 32'h0, 1'b0, 6'b010111},
    '{2'd1, 2'd0, 1'b1, 32'h0000_0080, 32'h0000_0001, 32'h0, 1'b0, 6'b100100},
    '{2'd0, 2'd1, 1'b1, 32'h0000_00FF, 32'h0000_0001, 32'h0, 1'b0, 6'b000110},
    '{2'd0, 2'd1, 1'b1, 32'h0000_8000, 32'h0000_8000, 32'h0, 1'b0, 6'b101011},
    '{2'd0, 2'd2, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 1'b0, 6'b001111},
    '{2'd1, 2'd3, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, 6'b110011},
    '{2'd2, 2'd0, 1'b1, 32'h0000_000F, 32'h0000_00F0, 32'h0000_0003, 1'b1, 6'b000010},
    '{2'd0, 2'd0, 1'b0, 32'h0000_0008, 32'h0000_0008, 32'h0000_0010, 1'b0, 6'b000100},
    '{2'd0, 2'd1, 1'b1, 32'h1234_0001, 32'hABCD_0001, 32'h0, 1'b0, 6'b000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, res_in = '0;
  logic        carry_in = 1'b0, use_int_adder = 1'b0;
  logic [1:0]  op_class = '0, width_sel = '0;
  logic        flag_we = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
  logic        trap_set = 1'b0, trap_clr = 1'b0, irq_req = 1'b0, instr_done = 1'b0;
  logic        flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of;
  logic [7:0]  flags_rd;
  logic        irq_take, trap_req;

  int n_run = 0;
  int n_fail = 0;
  logic [5:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .res_in(res_in),
    .carry_in(carry_in), .use_int_adder(use_int_adder), .op_class(op_class),
    .width_sel(width_sel), .flag_we(flag_we), .ien_set(ien_set), .ien_clr(ien_clr),
    .trap_set(trap_set), .trap_clr(trap_clr), .irq_req(irq_req), .instr_done(instr_done),
    .flag_cf(flag_cf), .flag_pf(flag_pf), .flag_af(flag_af), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .flag_of(flag_of), .flags_rd(flags_rd),
    .irq_take(irq_take), .trap_req(trap_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] live();
    return {flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R13 reset read port", {24'h0, flags_rd}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      op_class = VEC[i].cls; width_sel = VEC[i].wid; use_int_adder = VEC[i].ui;
      op_a = VEC[i].a; op_b = VEC[i].b; res_in = VEC[i].r; carry_in = VEC[i].ci;
      #1;
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 R9 vector %0d", i), {26'h0, live()}, {26'h0, VEC[i].exp});
      @(negedge clk);
    end

    // R13: capture last vector-like case, then hold when strobe low
    op_class = 2'd0; width_sel = 2'd0; use_int_adder = 1'b1;
    op_a = 32'h7F; op_b = 32'h01; last_exp = 6'b110100;
    flag_we = 1'b1;
    tick();
    flag_we = 1'b0;
    check("R13 capture", {26'h0, flags_rd[5:0]}, {26'h0, last_exp});
    op_a = 32'hFF;
    tick();
    check("R13 hold without strobe", {26'h0, flags_rd[5:0]}, {26'h0, last_exp});

    // R11 before enable
    irq_req = 1'b1; #1;
    check("R11 irq blocked", {31'h0, irq_take}, 32'h0);
    // R10 set
    ien_set = 1'b1; tick(); ien_set = 1'b0;
    check("R10 set", {31'h0, flags_rd[7]}, 32'h1);
    check("R11 irq taken", {31'h0, irq_take}, 32'h1);
    tick();
    check("R10 hold", {31'h0, flags_rd[7]}, 32'h1);
    ien_set = 1'b1; ien_clr = 1'b1; tick(); ien_set = 1'b0; ien_clr = 1'b0;
    check("R10 clear wins", {31'h0, flags_rd[7]}, 32'h0);
    irq_req = 1'b0;

    // R12 trap
    instr_done = 1'b1; #1;
    check("R12 no trap when clear", {31'h0, trap_req}, 32'h0);
    trap_set = 1'b1; tick(); trap_set = 1'b0;
    check("R12 trap bit", {31'h0, flags_rd[6]}, 32'h1);
    check("R12 trap request", {31'h0, trap_req}, 32'h1);
    instr_done = 1'b0; #1;
    check("R12 no request off boundary", {31'h0, trap_req}, 32'h0);
    trap_clr = 1'b1; tick(); trap_clr = 1'b0;
    instr_done = 1'b1; #1;
    check("R12 trap cleared", {31'h0, trap_req}, 32'h0);
    instr_done = 1'b0;

    // R8: bits above 8 in external result ignored
    use_int_adder = 1'b0; op_class = 2'd2; width_sel = 2'd0;
    res_in = 32'hFFFF_FF00; #1;
    check("R8 upper bits masked zero", {31'h0, flag_zf}, 32'h1);
    check("R2 parity low byte only", {31'h0, flag_pf}, 32'h1);

    // async reset clears all
    rst_n = 1'b0; #1;
    check("R13 reset clears", {24'h0, flags_rd}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule